// File: doc/BRIEF.md
# Periodic Serial ADC Result Reader

This block is the host side of a three-wire, read-only serial link to a delta-sigma converter. The converter works in a cycle: it converts, then waits in a low-power hold, then shifts out its 16-bit result. The reader owns the chip select and the serial clock and samples the converter's data line. It returns each result as a signed 16-bit word together with a one-cycle strobe. A read starts on a start request, or on an internal period timer when automatic mode is enabled.

All link timing comes from the system clock. The parameters set, in system-clock cycles, the serial-clock half period, the delay from chip select to the first clock activity, the hold-off that covers the converter's worst-case conversion time, and the automatic read period. Elaboration stops with an error when any of these falls short of the converter's minimum timing, given the nominal system-clock period passed in as a parameter.

The result leaves on a valid-only stream with no ready signal. The consumer cannot apply back-pressure, so it must take the word in the cycle the strobe is high. The word then stays unchanged until the next strobe. An abort input, or any other early end of a frame, discards that frame: the reader gives a drop pulse in place of the strobe.

Top module: `serial_adc_reader`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, and the valid and drop outputs are low. After reset is released, chip select stays high for at least CONV_WAIT_CYC cycles before the first frame opens.
- R2: A frame opens by lowering chip select while the serial clock is low. The serial clock then stays low for exactly SETUP_CYC + HALF_CYC cycles before its first rising edge.
- R3: Within a frame, every later high phase and low phase of the serial clock lasts exactly HALF_CYC cycles.
- R4: A complete frame has 16 rising edges. The data line is captured at each rising edge, and the first captured bit is bit 15, the sign, so the word arrives MSB first. The result is read as two's complement.
- R5: The valid output is high for exactly one cycle per completed frame. The result output does not change in any cycle where valid is low.
- R6: Chip select is raised HALF_CYC cycles after the 16th falling edge of the serial clock. It then stays high for at least CONV_WAIT_CYC cycles before the next frame opens.
- R7: A start request that arrives while the reader is not idle is held. That read opens one cycle after the conversion hold-off ends, so chip select is high for exactly CONV_WAIT_CYC + 1 cycles between the frames.
- R8: With automatic mode on, frames open exactly PERIOD_CYC cycles apart, provided a frame plus the hold-off fits inside that period. With automatic mode off and no start request, no frame opens.
- R9: An abort makes chip select high and the serial clock low in the next cycle. A frame aborted before its 16th falling edge gives no valid strobe. It gives a one-cycle drop pulse that never coincides with valid. The conversion hold-off restarts from the abort, so a start made during the hold-off opens its frame CONV_WAIT_CYC + 1 cycles after the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start_i | input | 1 | Request one read (held if the reader is busy) |
| abort_i | input | 1 | Abandon any frame and restart the conversion hold-off |
| auto_en_i | input | 1 | Enable reads from the internal period timer |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter, idle low |
| res_data_o | output | DATA_W | Last completed result, two's complement |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_drop_o | output | 1 | One-cycle pulse: frame aborted, no result |

## Verification
The hardest state to reach from the ports is an abort that lands inside a frame at a chosen bit, and then checking that the hold-off restarts from that point rather than from the frame's start. The stimulus watches the serial clock, counts its rising edges, raises abort after the fifth one, and then issues a start during the restarted hold-off. This checks the drop pulse, the missing strobe and the exact chip-select gap all at once. A second hard case is a start that arrives while the previous frame's tail is still running. The table walk triggers that case on purpose by issuing each start right after the previous strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_CONV  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SETUP = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4,
    ST_TAIL  = 3'd5
  } rd_state_e;
endpackage

// File: rtl/rd_countdown.sv
module rd_countdown #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= RST_VAL;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rd_shift_capture.sv
module rd_shift_capture #(
  parameter int DATA_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_adv,
  input  logic              din,
  output logic [DATA_W-1:0] word,
  output logic              last_bit
);
  logic [BIT_W-1:0] bit_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word      <= '0;
      bit_cnt_q <= '0;
    end else begin
      if (clr)          bit_cnt_q <= '0;
      else if (bit_adv) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (shift_en)     word <= {word[DATA_W-2:0], din};
    end
  end

  assign last_bit = (bit_cnt_q == BIT_W'(DATA_W - 1));
endmodule

// File: rtl/rd_seq_fsm.sv
module rd_seq_fsm
  import adc_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic abort_req,
  input  logic auto_en,
  input  logic ph_zero,
  input  logic conv_zero,
  input  logic per_zero,
  input  logic last_bit,
  output logic cs_n,
  output logic sck,
  output logic ph_load,
  output logic ph_setup,
  output logic conv_load,
  output logic per_load,
  output logic frame_clr,
  output logic shift_en,
  output logic bit_adv,
  output logic commit,
  output logic drop
);
  rd_state_e st_q, st_d;
  logic      pend_q, pend_d;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    ph_load   = 1'b0;
    ph_setup  = 1'b0;
    conv_load = 1'b0;
    per_load  = 1'b0;
    frame_clr = 1'b0;
    shift_en  = 1'b0;
    bit_adv   = 1'b0;
    commit    = 1'b0;
    drop      = 1'b0;
    if (abort_req) begin
      st_d      = ST_CONV;
      conv_load = 1'b1;
      pend_d    = 1'b0;
      drop      = (st_q == ST_SETUP) || (st_q == ST_LOW) || (st_q == ST_HIGH);
    end else begin
      if (start_req && st_q != ST_IDLE) pend_d = 1'b1;
      unique case (st_q)
        ST_CONV: if (conv_zero) st_d = ST_IDLE;
        ST_IDLE: begin
          if (pend_q || start_req || (auto_en && per_zero)) begin
            st_d      = ST_SETUP;
            ph_load   = 1'b1;
            ph_setup  = 1'b1;
            per_load  = 1'b1;
            frame_clr = 1'b1;
            pend_d    = 1'b0;
          end
        end
        ST_SETUP: begin
          if (ph_zero) begin
            st_d    = ST_LOW;
            ph_load = 1'b1;
          end
        end
        ST_LOW: begin
          if (ph_zero) begin
            st_d     = ST_HIGH;
            ph_load  = 1'b1;
            shift_en = 1'b1;
          end
        end
        ST_HIGH: begin
          if (ph_zero) begin
            ph_load = 1'b1;
            bit_adv = 1'b1;
            if (last_bit) begin
              st_d   = ST_TAIL;
              commit = 1'b1;
            end else begin
              st_d = ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (ph_zero) begin
            st_d      = ST_CONV;
            conv_load = 1'b1;
          end
        end
        default: st_d = ST_CONV;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_CONV;
      pend_q <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cs_n   <= !(st_d inside {ST_SETUP, ST_LOW, ST_HIGH, ST_TAIL});
      sck    <= (st_d == ST_HIGH);
    end
  end
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int DATA_W        = 16,
  parameter int CLK_NS        = 10,
  parameter int HALF_CYC      = 30,
  parameter int SETUP_CYC     = 12,
  parameter int CONV_WAIT_CYC = 2_300_000,
  parameter int CONV_MAX_NS   = 23_000_000,
  parameter int PERIOD_CYC    = 10_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     abort_i,
  input  logic                     auto_en_i,
  input  logic                     adc_sdo_i,
  output logic                     adc_cs_n_o,
  output logic                     adc_sck_o,
  output logic signed [DATA_W-1:0] res_data_o,
  output logic                     res_valid_o,
  output logic                     res_drop_o
);
  localparam int PH_MAX = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CW_W   = $clog2(CONV_WAIT_CYC + 1);
  localparam int PER_W  = $clog2(PERIOD_CYC + 1);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  SETUP_LD = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  HALF_LD  = PH_W'(HALF_CYC - 1);
  localparam logic [CW_W-1:0]  CONV_LD  = CW_W'(CONV_WAIT_CYC - 1);
  localparam logic [PER_W-1:0] PER_LD   = PER_W'(PERIOD_CYC - 1);

  // Elaboration-time limits of the converter link
  if (HALF_CYC < 1 || SETUP_CYC < 1 || CONV_WAIT_CYC < 1 || PERIOD_CYC < 1) begin : g_bad_zero
    $error("serial_adc_reader: cycle counts must be at least one");
  end
  if (longint'(HALF_CYC) * longint'(CLK_NS) < 64'sd250) begin : g_bad_half
    $error("serial_adc_reader: serial clock phase shorter than 250 ns");
  end
  if (longint'(SETUP_CYC) * longint'(CLK_NS) < 64'sd100) begin : g_bad_setup
    $error("serial_adc_reader: select-to-clock setup shorter than 100 ns");
  end
  if (longint'(CONV_WAIT_CYC) * longint'(CLK_NS) < longint'(CONV_MAX_NS)) begin : g_bad_wait
    $error("serial_adc_reader: hold-off shorter than worst-case conversion");
  end

  logic ph_load, ph_setup, ph_zero;
  logic conv_load, conv_zero;
  logic per_load, per_zero;
  logic frame_clr, shift_en, bit_adv, commit, drop, last_bit;
  logic [PH_W-1:0]   ph_val;
  logic [DATA_W-1:0] shreg;

  assign ph_val = ph_setup ? SETUP_LD : HALF_LD;

  rd_countdown #(.W(PH_W), .RST_VAL('0)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  rd_countdown #(.W(CW_W), .RST_VAL(CONV_LD)) u_conv_tmr (
    .clk(clk), .rst_n(rst_n), .load(conv_load), .load_val(CONV_LD), .zero(conv_zero)
  );

  rd_countdown #(.W(PER_W), .RST_VAL('0)) u_period_tmr (
    .clk(clk), .rst_n(rst_n), .load(per_load), .load_val(PER_LD), .zero(per_zero)
  );

  rd_shift_capture #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .shift_en(shift_en),
    .bit_adv(bit_adv), .din(adc_sdo_i), .word(shreg), .last_bit(last_bit)
  );

  rd_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_i), .abort_req(abort_i),
    .auto_en(auto_en_i), .ph_zero(ph_zero), .conv_zero(conv_zero),
    .per_zero(per_zero), .last_bit(last_bit), .cs_n(adc_cs_n_o), .sck(adc_sck_o),
    .ph_load(ph_load), .ph_setup(ph_setup), .conv_load(conv_load),
    .per_load(per_load), .frame_clr(frame_clr), .shift_en(shift_en),
    .bit_adv(bit_adv), .commit(commit), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data_o  <= '0;
      res_valid_o <= 1'b0;
      res_drop_o  <= 1'b0;
    end else begin
      res_valid_o <= commit;
      res_drop_o  <= drop;
      if (commit) res_data_o <= $signed(shreg);
    end
  end
endmodule

// File: rtl/serial_adc_reader_chk.sv
module serial_adc_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              adc_cs_n_o,
  input logic              adc_sck_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              res_valid_o,
  input logic              res_drop_o
);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> $stable(res_data_o));

  // R2
  cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n_o) |-> !adc_sck_o);

  // R6
  cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n_o) |-> !adc_sck_o);

  // R3
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_sck_o) |-> !$past(adc_cs_n_o));

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (adc_cs_n_o && !adc_sck_o && !res_valid_o));

  // R9
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop_o |-> !res_valid_o);
endmodule

bind serial_adc_reader serial_adc_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .adc_cs_n_o(adc_cs_n_o),
  .adc_sck_o(adc_sck_o), .res_data_o(res_data_o), .res_valid_o(res_valid_o),
  .res_drop_o(res_drop_o)
);

// File: tb/serial_adc_reader_test.sv
module serial_adc_reader_test;
  localparam int CLK_PERIOD = 100;
  localparam int HALF  = 3;
  localparam int SETUP = 2;
  localparam int CONVW = 40;
  localparam int PER   = 300;
  localparam int NVEC  = 8;
  localparam logic [15:0] VEC_WORD [NVEC] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                                              16'h1234, 16'hA5A5, 16'h0001, 16'hFFFE};
  localparam int VEC_EXP [NVEC] = '{0, 32767, -32768, -1, 4660, -23131, 1, -2};

  logic clk, rst_n, start, abort, auto_en, sdo, cs_n, sck, valid, drop;
  logic signed [15:0] data;
  logic [15:0] model_word;
  int mdl_fall;
  int n_chk, n_bad;

  serial_adc_reader #(
    .DATA_W(16), .CLK_NS(CLK_PERIOD), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
    .CONV_WAIT_CYC(CONVW), .CONV_MAX_NS(CONVW * CLK_PERIOD), .PERIOD_CYC(PER)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .auto_en_i(auto_en),
    .adc_sdo_i(sdo), .adc_cs_n_o(cs_n), .adc_sck_o(sck), .res_data_o(data),
    .res_valid_o(valid), .res_drop_o(drop)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Converter model: sign bit out as soon as select falls, next bit after each falling clock
  initial mdl_fall = 0;
  always @(negedge sck or posedge cs_n) begin
    if (cs_n) mdl_fall = 0;
    else      mdl_fall = mdl_fall + 1;
  end
  assign sdo = (mdl_fall < 16) ? model_word[15 - mdl_fall] : 1'b0;

  // Port monitor, sampled on the falling system-clock edge
  int cyc = 0, rises = 0, run_len = 0, first_low = 0, bad_phase = 0;
  int cs_hi_len = 0, last_gap = 0, gap_viol = 0, tail_bad = 0, frames = 0;
  int fstart = 0, fstart_prev = 0, valid_cnt = 0, drop_cnt = 0, valid_multi = 0, stab_viol = 0;
  bit first_flag = 1'b0;
  logic prev_cs = 1'b1, prev_sck = 1'b0, prev_valid = 1'b0;
  logic [15:0] held = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n) begin
        if (prev_cs) begin
          frames++;
          fstart_prev = fstart;
          fstart = cyc;
          last_gap = cs_hi_len;
          if (cs_hi_len < CONVW) gap_viol++;
          rises = 0;
          run_len = 1;
          first_flag = 1'b1;
        end else if (sck != prev_sck) begin
          if (first_flag) begin
            first_low = run_len;
            first_flag = 1'b0;
          end else if (run_len != HALF) begin
            bad_phase++;
          end
          if (sck) rises++;
          run_len = 1;
        end else begin
          run_len++;
        end
      end else begin
        if (!prev_cs) begin
          if (rises == 16 && run_len != HALF) tail_bad++;
          cs_hi_len = 1;
        end else begin
          cs_hi_len++;
        end
      end
      if (valid) begin
        valid_cnt++;
        if (prev_valid) valid_multi++;
        held = data;
      end else if (data !== held) begin
        stab_viol++;
      end
      if (drop) drop_cnt++;
      prev_cs = cs_n;
      prev_sck = sck;
      prev_valid = valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid();
    int v0 = valid_cnt;
    while (valid_cnt == v0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v0, d0, f0, t1, t2;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start = 1'b0;
    abort = 1'b0;
    auto_en = 1'b0;
    model_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
    check(sck == 1'b0, "R1 sck in reset", int'(sck), 0);
    check(valid == 1'b0 && drop == 1'b0, "R1 valid/drop in reset", int'(valid) + int'(drop), 0);
    rst_n = 1'b1;

    // Table walk: R4 data, R2 opening, R7 held start (each start issued during the tail)
    for (int i = 0; i < NVEC; i++) begin
      model_word = VEC_WORD[i];
      pulse_start();
      wait_valid();
      check(int'(data) == VEC_EXP[i], "R4 result word", int'(data), VEC_EXP[i]);
      check(rises == 16, "R4 rising edges per frame", rises, 16);
      check(first_low == SETUP + HALF, "R2 first low span", first_low, SETUP + HALF);
      if (i == 0) check(last_gap >= CONVW, "R1 hold-off after reset", last_gap, CONVW);
      else        check(last_gap == CONVW + 1, "R7 held start gap", last_gap, CONVW + 1);
    end

    // R5: result held with no strobe
    repeat (60) @(negedge clk);
    check(int'(data) == VEC_EXP[NVEC-1], "R5 result held", int'(data), VEC_EXP[NVEC-1]);
    check(valid_cnt == NVEC, "R5 one strobe per frame", valid_cnt, NVEC);

    // R9: abort after the fifth rising edge
    model_word = 16'h5A5A;
    f0 = frames;
    v0 = valid_cnt;
    d0 = drop_cnt;
    pulse_start();
    while (!(frames > f0 && rises >= 5)) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(cs_n == 1'b1 && sck == 1'b0, "R9 link released", int'(cs_n) * 2 + int'(sck), 2);
    model_word = 16'h0F0F;
    pulse_start();
    @(negedge clk);
    check(drop_cnt == d0 + 1, "R9 drop pulse", drop_cnt, d0 + 1);
    check(valid_cnt == v0, "R9 no strobe for aborted frame", valid_cnt, v0);
    wait_valid();
    check(last_gap == CONVW + 1, "R9 hold-off restarts at abort", last_gap, CONVW + 1);
    check(int'(data) == 16'h0F0F, "R9 next read intact", int'(data), 16'h0F0F);

    // R8: no frame without a trigger
    f0 = frames;
    repeat (2 * PER) @(negedge clk);
    check(frames == f0, "R8 idle without trigger", frames, f0);

    // R8: automatic period
    model_word = 16'h3C3C;
    auto_en = 1'b1;
    while (frames < f0 + 2) @(negedge clk);
    @(negedge clk);
    t1 = fstart - fstart_prev;
    while (frames < f0 + 3) @(negedge clk);
    @(negedge clk);
    t2 = fstart - fstart_prev;
    auto_en = 1'b0;
    check(t1 == PER, "R8 period first", t1, PER);
    check(t2 == PER, "R8 period second", t2, PER);
    wait_valid();
    check(int'(data) == 16'h3C3C, "R8 auto read data", int'(data), 16'h3C3C);

    // Accumulated monitor results
    check(bad_phase == 0, "R3 phase length", bad_phase, 0);
    check(tail_bad == 0, "R6 tail length", tail_bad, 0);
    check(gap_viol == 0, "R6 hold-off between frames", gap_viol, 0);
    check(valid_multi == 0, "R5 single-cycle strobe", valid_multi, 0);
    check(stab_viol == 0, "R5 no change without strobe", stab_viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule